// File: doc/BRIEF.md
# Battery Charge Control Sequencer

This block is the digital controller of a single-cell lithium charger. It watches a supply-present flag and an enable bit and, once both are true, walks the cell through a low-current precharge phase, a constant-current phase, a constant-voltage phase and a finished phase. It drives a 4-bit current setpoint for the analog pass device and reports the charge phase as a 3-bit code. The pass device, converters and comparators sit outside; the block only sees their flags.

While charging in the constant-current or constant-voltage phase, a die-temperature flag lowers the setpoint one step at a time. A cool flag, meaning the die is below the threshold less a hysteresis margin, raises it again. A dwell timer clocked by a slow 32 kHz tick spaces the steps. A battery under-voltage or over-voltage flag moves the sequencer to a safety state with zero current for a fixed number of ticks. After that it either resumes charging or terminates, depending on whether the fault is still present.

States and transitions: IDLE to PRE or CC on start; PRE to CC when the low-battery flag clears; CC to CV on the full flag; CV to DONE on the taper flag; PRE, CC or CV to SAFE on a fault; SAFE to PRE or TERM on safety expiry; any state back to IDLE when supply or enable drops.

Top module: `chg_seq`

## Requirements
- R1: After reset the phase code is 0 (IDLE), the setpoint is 0, and every flag output is 0. Phase codes are IDLE=0, PRE=1, CC=2, CV=3, DONE=4, SAFE=5, TERM=6.
- R2: In IDLE with supply_ok and enable both high, the next clock enters PRE if bat_low is high, otherwise CC. irq_start is high for exactly that one cycle.
- R3: In any state, if supply_ok or enable is low at a clock edge, the phase becomes IDLE and the setpoint 0 after that edge.
- R4: In PRE the setpoint is 1. When bat_low is low, the next clock enters CC with the setpoint at max_code.
- R5: CC moves to CV when bat_full is high, and CV moves to DONE when taper_done is high. DONE holds setpoint 0 until supply or enable drops.
- R6: In CC or CV, if temp_hot is high and the dwell timer has run out, the setpoint drops by 1 (never below 1) and the timer reloads DWELL_TICKS ticks.
- R7: In CC or CV, if temp_hot is low, temp_cool is high and the dwell timer has run out, the setpoint rises by 1 (never above max_code) and the timer reloads.
- R8: A high bat_uv or bat_ov in PRE, CC or CV enters SAFE on the next clock. The setpoint is 0, irq_fault pulses for one cycle, and fault_uv and fault_ov show the flags captured at entry.
- R9: SAFE lasts SAFE_TICKS ticks. If bat_uv or bat_ov is still high when it expires, the phase goes to TERM and stays there with the fault flags held until supply or enable drops. Otherwise it goes to PRE and the flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle 32 kHz timebase pulse |
| supply_ok | input | 1 | External supply detected |
| enable | input | 1 | Charging allowed |
| bat_low | input | 1 | Cell below precharge threshold |
| bat_full | input | 1 | Cell reached regulation voltage |
| taper_done | input | 1 | Current tapered below termination level |
| bat_uv | input | 1 | Cell under-voltage fault |
| bat_ov | input | 1 | Cell over-voltage fault |
| temp_hot | input | 1 | Die at or above foldback threshold |
| temp_cool | input | 1 | Die below threshold minus hysteresis |
| max_code | input | 4 | Programmed maximum setpoint (1..15, stable while charging) |
| iset | output | 4 | Current setpoint code |
| phase | output | 3 | Charge phase code |
| fault_uv | output | 1 | Under-voltage captured at safety entry |
| fault_ov | output | 1 | Over-voltage captured at safety entry |
| irq_start | output | 1 | Charge-start interrupt pulse |
| irq_fault | output | 1 | Fault interrupt pulse |

## Verification
A corrupted state register shows at once on the phase code and usually on the setpoint in the cycle after the bad edge. A lost or stuck safety count shows as an early or missing move out of phase 5, visible a few ticks later. An error in the foldback code or its dwell timer shows as a setpoint that moves by more than one step, moves too early or too late, or leaves the 1..max_code band. A wrong timing is seen within one dwell period. The bench runs a behavioural model beside the design and compares all outputs on every clock, so any such divergence is reported in the cycle it first appears.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRE  = 3'd1,
        ST_CC   = 3'd2,
        ST_CV   = 3'd3,
        ST_DONE = 3'd4,
        ST_SAFE = 3'd5,
        ST_TERM = 3'd6
    } chg_state_t;
endpackage

// File: rtl/chg_tick_timer.sv
module chg_tick_timer #(
    parameter int RELOAD = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic load,
    input  logic clear,
    output logic expired
);
    localparam int W = $clog2(RELOAD + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (load)
            cnt <= W'(RELOAD);
        else if (tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= W'(RELOAD));
endmodule

// File: rtl/chg_foldback.sv
module chg_foldback #(
    parameter int CODE_W      = 4,
    parameter int DWELL_TICKS = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              active,
    input  logic              hot,
    input  logic              cool,
    input  logic [CODE_W-1:0] max_code,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

    logic [CODE_W-1:0] ceil_code;
    logic              dwell_done;
    logic              step_dn;
    logic              step_up;

    assign ceil_code = (max_code == '0) ? ONE : max_code;
    assign step_dn   = active && hot && dwell_done && (code > ONE);
    assign step_up   = active && !hot && cool && dwell_done && (code < ceil_code);

    chg_tick_timer #(.RELOAD(DWELL_TICKS)) u_dwell (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .load    (step_dn || step_up),
        .clear   (!active),
        .expired (dwell_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            code <= ONE;
        else if (!active)
            code <= ceil_code;
        else if (step_dn)
            code <= code - ONE;
        else if (step_up)
            code <= code + ONE;
    end

    p_code_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> code >= ONE);
    p_code_ceiling_r7: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> code <= ceil_code);
    p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |->
        (code == $past(code) || code == $past(code) + ONE || code + ONE == $past(code)));
endmodule

// File: rtl/chg_seq.sv
module chg_seq
    import chg_seq_pkg::*;
#(
    parameter int CODE_W      = 4,
    parameter int DWELL_TICKS = 8192,
    parameter int SAFE_TICKS  = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              supply_ok,
    input  logic              enable,
    input  logic              bat_low,
    input  logic              bat_full,
    input  logic              taper_done,
    input  logic              bat_uv,
    input  logic              bat_ov,
    input  logic              temp_hot,
    input  logic              temp_cool,
    input  logic [CODE_W-1:0] max_code,
    output logic [CODE_W-1:0] iset,
    output logic [2:0]        phase,
    output logic              fault_uv,
    output logic              fault_ov,
    output logic              irq_start,
    output logic              irq_fault
);
    chg_state_t        state, state_nx;
    logic              run;
    logic              fault;
    logic              in_reg;
    logic              safe_done;
    logic              enter_safe;
    logic              keep_flags;
    logic [CODE_W-1:0] fold_code;

    assign run        = supply_ok && enable;
    assign fault      = bat_uv || bat_ov;
    assign in_reg     = (state == ST_CC) || (state == ST_CV);
    assign enter_safe = (state_nx == ST_SAFE) && (state != ST_SAFE);
    assign keep_flags = (state_nx == ST_SAFE) || (state_nx == ST_TERM);

    // next-state logic
    always_comb begin
        state_nx = state;
        if (!run) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = bat_low ? ST_PRE : ST_CC;
                ST_PRE:  if (fault) state_nx = ST_SAFE;
                         else if (!bat_low) state_nx = ST_CC;
                ST_CC:   if (fault) state_nx = ST_SAFE;
                         else if (bat_full) state_nx = ST_CV;
                ST_CV:   if (fault) state_nx = ST_SAFE;
                         else if (taper_done) state_nx = ST_DONE;
                ST_DONE: state_nx = ST_DONE;
                ST_SAFE: if (safe_done) state_nx = fault ? ST_TERM : ST_PRE;
                ST_TERM: state_nx = ST_TERM;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    chg_tick_timer #(.RELOAD(SAFE_TICKS)) u_safe_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .load    (enter_safe),
        .clear   (1'b0),
        .expired (safe_done)
    );

    chg_foldback #(.CODE_W(CODE_W), .DWELL_TICKS(DWELL_TICKS)) u_fold (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .active   (in_reg),
        .hot      (temp_hot),
        .cool     (temp_cool),
        .max_code (max_code),
        .code     (fold_code)
    );

    // registered flag outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_start <= 1'b0;
            irq_fault <= 1'b0;
            fault_uv  <= 1'b0;
            fault_ov  <= 1'b0;
        end else begin
            irq_start <= (state == ST_IDLE) && (state_nx != ST_IDLE);
            irq_fault <= enter_safe;
            if (!keep_flags) begin
                fault_uv <= 1'b0;
                fault_ov <= 1'b0;
            end else if (enter_safe) begin
                fault_uv <= bat_uv;
                fault_ov <= bat_ov;
            end
        end
    end

    // setpoint and phase decode
    always_comb begin
        unique case (state)
            ST_PRE:        iset = CODE_W'(1);
            ST_CC, ST_CV:  iset = fold_code;
            default:       iset = '0;
        endcase
    end
    assign phase = state;

    p_drop_to_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> phase == 3'(ST_IDLE));
    p_safe_no_current_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SAFE || state == ST_TERM) |-> iset == '0);
    p_fault_irq_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fault |-> state == ST_SAFE);
    p_start_irq_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_start |-> $past(state) == ST_IDLE);
    p_term_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TERM && run) |=> state == ST_TERM);
endmodule

// File: tb/chg_seq_bench.sv
module chg_seq_bench;
    localparam int DW = 3;
    localparam int SW = 4;
    localparam int MAXC = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic supply_ok = 0, enable = 0, bat_low = 0, bat_full = 0, taper_done = 0;
    logic bat_uv = 0, bat_ov = 0, temp_hot = 0, temp_cool = 0;
    logic [3:0] max_code = 4'(MAXC);
    logic [3:0] iset;
    logic [2:0] phase;
    logic fault_uv, fault_ov, irq_start, irq_fault;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";
    bit done = 0;

    always #2 clk = ~clk;

    chg_seq #(.CODE_W(4), .DWELL_TICKS(DW), .SAFE_TICKS(SW)) u_chg_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok), .enable(enable),
        .bat_low(bat_low), .bat_full(bat_full), .taper_done(taper_done),
        .bat_uv(bat_uv), .bat_ov(bat_ov), .temp_hot(temp_hot), .temp_cool(temp_cool),
        .max_code(max_code), .iset(iset), .phase(phase), .fault_uv(fault_uv),
        .fault_ov(fault_ov), .irq_start(irq_start), .irq_fault(irq_fault));

    // behavioural reference
    int m_st, m_code, m_ft, m_stt, m_uv, m_ov, m_is, m_if;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_code = 1; m_ft = 0; m_stt = 0;
            m_uv = 0; m_ov = 0; m_is = 0; m_if = 0;
        end else begin
            int nst;
            bit run, flt, reg_ph;
            run = supply_ok && enable;
            flt = bat_uv || bat_ov;
            reg_ph = (m_st == 2 || m_st == 3);
            nst = m_st;
            if (!run) nst = 0;
            else if (m_st == 0) nst = bat_low ? 1 : 2;
            else if (m_st >= 1 && m_st <= 3 && flt) nst = 5;
            else if (m_st == 1 && !bat_low) nst = 2;
            else if (m_st == 2 && bat_full) nst = 3;
            else if (m_st == 3 && taper_done) nst = 4;
            else if (m_st == 5 && m_stt == 0) nst = flt ? 6 : 1;
            if (!reg_ph) begin m_code = MAXC; m_ft = 0; end
            else if (temp_hot && m_ft == 0 && m_code > 1) begin m_code--; m_ft = DW; end
            else if (!temp_hot && temp_cool && m_ft == 0 && m_code < MAXC) begin m_code++; m_ft = DW; end
            else if (tick && m_ft > 0) m_ft--;
            if (nst == 5 && m_st != 5) m_stt = SW;
            else if (tick && m_stt > 0) m_stt--;
            m_is = (m_st == 0 && nst != 0);
            m_if = (nst == 5 && m_st != 5);
            if (nst != 5 && nst != 6) begin m_uv = 0; m_ov = 0; end
            else if (m_if) begin m_uv = bat_uv; m_ov = bat_ov; end
            m_st = nst;
        end
    end

    function automatic int m_iset();
        if (m_st == 1) return 1;
        if (m_st == 2 || m_st == 3) return m_code;
        return 0;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({cur_req, " outputs"},
                {phase, iset, fault_uv, fault_ov, irq_start, irq_fault},
                {3'(m_st), 4'(m_iset()), 1'(m_uv), 1'(m_ov), 1'(m_is), 1'(m_if)});
        end
    end

    // 32 kHz tick stand-in: one pulse every 4 cycles
    int tcnt = 0;
    always @(negedge clk) begin
        tcnt = (tcnt + 1) % 4;
        tick = (tcnt == 0);
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        cur_req = "R1";
        chk("R1 phase", phase, 0);
        chk("R1 iset", iset, 0);
        chk("R1 flags", {fault_uv, fault_ov, irq_start, irq_fault}, 0);

        cur_req = "R2";
        bat_low = 1; supply_ok = 1; enable = 1;
        cyc(1);
        chk("R2 phase", phase, 1);
        chk("R2 irq_start", irq_start, 1);
        cyc(1);
        chk("R2 irq_start width", irq_start, 0);
        cur_req = "R4";
        chk("R4 precharge iset", iset, 1);
        bat_low = 0;
        cyc(1);
        chk("R4 phase", phase, 2);
        chk("R4 iset", iset, MAXC);

        cur_req = "R6";
        temp_hot = 1;
        cyc(80);
        chk("R6 floor", iset, 1);
        cur_req = "R7";
        temp_hot = 0; temp_cool = 1;
        cyc(80);
        chk("R7 ceiling", iset, MAXC);
        temp_cool = 0;

        cur_req = "R5";
        bat_full = 1;
        cyc(1);
        chk("R5 cv", phase, 3);
        bat_full = 0;
        temp_hot = 1;
        cyc(20);
        temp_hot = 0;
        taper_done = 1;
        cyc(1);
        chk("R5 done", phase, 4);
        chk("R5 done iset", iset, 0);
        taper_done = 0;

        cur_req = "R3";
        supply_ok = 0;
        cyc(1);
        chk("R3 supply drop", phase, 0);
        supply_ok = 1;
        cyc(3);
        enable = 0;
        cyc(1);
        chk("R3 enable drop", phase, 0);
        chk("R3 iset", iset, 0);
        enable = 1;
        cyc(3);

        cur_req = "R8";
        bat_ov = 1;
        cyc(1);
        chk("R8 safe", phase, 5);
        chk("R8 iset", iset, 0);
        chk("R8 irq_fault", irq_fault, 1);
        chk("R8 fault_ov", fault_ov, 1);
        cur_req = "R9";
        cyc(30);
        chk("R9 term", phase, 6);
        chk("R9 term flag", fault_ov, 1);
        bat_ov = 0;
        cyc(5);
        chk("R9 term holds", phase, 6);
        supply_ok = 0;
        cyc(2);
        supply_ok = 1;
        cyc(3);

        bat_uv = 1;
        cyc(2);
        chk("R8 fault_uv", fault_uv, 1);
        bat_uv = 0;
        cyc(30);
        chk("R9 resumed", phase, 2);
        chk("R9 flags cleared", {fault_uv, fault_ov}, 0);
        cyc(4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cyc(20000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule